// File: doc/BRIEF.md
# Configuration Window Bridge with One-Hot Device Select

This block sits on a CPU-side memory bus and turns accesses that fall inside a fixed 4 MiB window into configuration-space requests for a peripheral bus. The CPU address carries an 11-bit one-hot device-select field above an 11-bit register offset. The bridge finds the lowest set select bit and converts its position into a binary device index. It then builds a compact configuration address from that index and the offset. The CPU side is big-endian, so 16-bit and 32-bit data are byte-reversed in both directions. Byte data passes straight through.

The bridge also answers for its own device, a host bridge. This is the device reached when no select bit is set. It answers from a small read-only header and never forwards these accesses. It handles one transaction at a time. A read returns a registered response that stays put until the CPU takes it. A read that the configuration side marks as reaching no device returns all ones, sized to the access.

Top module: `cfgwin_bridge`

## Requirements
- R1: An access is claimed (`cpu_ready` high while idle) only when `cpu_addr[31:22]` equals the top bits of the window base 0x8080_0000. Out-of-window requests never see `cpu_ready` and cause no configuration request and no response.
- R2: The device index is the position, counted from bit 11, of the lowest set bit among `cpu_addr[21:11]`. Higher set bits are ignored. With none set the index is 11, which selects the bridge itself.
- R3: A forwarded request drives `cfg_addr` = {index (4 bits), `cpu_addr[10:0]`} on a 15-bit bus. It also copies `cpu_size` to `cfg_size` and `cpu_write` to `cfg_write`.
- R4: The size code is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Code 3 is never claimed.
- R5: Write data reaches `cfg_wdata` as follows. For size 0 it is `cpu_wdata[7:0]`. For size 1 it is `{cpu_wdata[7:0],cpu_wdata[15:8]}`. For size 2 it is the four bytes of `cpu_wdata` in reverse order. Unused upper lanes are zero.
- R6: Read data from `cfg_rdata` reaches `cpu_rdata` with the same per-size lane rule as R5, zero-extended.
- R7: A forwarded read acknowledged with `cfg_nodev` high returns all ones of the access width: 0xFF, 0xFFFF or 0xFFFF_FFFF.
- R8: Index 11 is served locally, with no configuration request. The header is little-endian by dword: offset 0x00 = {device id 0x4801, vendor id 0x1F2E}, 0x08 = 0x0600_0000 (revision 0x00, host-bridge class), 0x0C = 0x0000_1008 (latency 0x10, cache line 0x08), 0x34 = 0x0000_0000 (capabilities pointer), and every other offset reads zero. A read returns the dword shifted right by 8 × (offset mod 4), then processed by the R6 lane rule. Writes to it are dropped, and the bridge is free again in the next cycle.
- R9: Only one transaction is outstanding. `cpu_ready` stays low from acceptance until the configuration acknowledge of a forwarded write, or until the CPU takes a read response. A request held during the acknowledge cycle is not accepted in that cycle.
- R10: While `cfg_valid` is high and `cfg_ready` low, all configuration request fields hold stable.
- R11: `cpu_rvalid` and `cpu_rdata` are registered and hold stable until `cpu_rready`. Later changes on `cfg_rdata` do not affect them.
- R12: Synchronous active-high `rst` drops `cfg_valid` and `cpu_rvalid` at the next edge, including in the middle of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | Request claimed and accepted this cycle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 2 | Size code (R4) |
| cpu_wdata | input | 32 | Big-endian write data |
| cpu_rvalid | output | 1 | Read response valid |
| cpu_rready | input | 1 | CPU takes read response |
| cpu_rdata | output | 32 | Big-endian read data |
| cfg_valid | output | 1 | Configuration request valid |
| cfg_ready | input | 1 | Configuration acknowledge |
| cfg_write | output | 1 | Configuration write |
| cfg_addr | output | 15 | Device index and register offset |
| cfg_size | output | 2 | Size code |
| cfg_wdata | output | 32 | Little-endian write data |
| cfg_rdata | input | 32 | Read data, valid with acknowledge |
| cfg_nodev | input | 1 | No device answered, valid with acknowledge |

## Verification
Two events can meet in one cycle: the configuration acknowledge that ends a transaction, and a fresh CPU request waiting to start the next one. The bench holds `cpu_valid` high with a valid in-window address for the whole of every forwarded transaction, including the acknowledge cycle. It then judges that `cpu_ready` stays low through that edge. It also checks that `cpu_ready` is back only in the following cycle for writes, and only after the response is taken for reads. A related collision is a reset in the middle of a transaction. This is provoked during a pending configuration read and judged by both valid outputs dropping at that edge.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CFG  = 2'd1,
      ST_RESP = 2'd2
   } bridge_st_e;

   // all-ones pattern of the access width
   function automatic logic [31:0] size_ones(acc_size_e s);
      case (s)
         SZ_BYTE: size_ones = 32'h0000_00FF;
         SZ_HALF: size_ones = 32'h0000_FFFF;
         default: size_ones = 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/cfgwin_decode.sv
module cfgwin_decode #(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8080_0000,
   parameter int                WIN_BITS = 22,
   parameter int                OFS_BITS = 11,
   parameter int                NSEL     = 11,
   localparam int               IDX_W    = $clog2(NSEL + 1)
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic                hit,
   output logic [IDX_W-1:0]    idx,
   output logic [OFS_BITS-1:0] ofs
);
   localparam int TOP_W = ADDR_W - WIN_BITS;

   logic [NSEL-1:0]  sel;
   logic [TOP_W-1:0] win_tag;

   assign win_tag = WIN_BASE[ADDR_W-1:WIN_BITS];
   assign hit     = (addr[ADDR_W-1:WIN_BITS] == win_tag);
   assign sel     = addr[OFS_BITS +: NSEL];
   assign ofs     = addr[OFS_BITS-1:0];

   // lowest set select bit wins; none set gives NSEL
   always_comb begin
      idx = IDX_W'(NSEL);
      for (int i = NSEL - 1; i >= 0; i--) begin
         if (sel[i]) idx = IDX_W'(i);
      end
   end

   generate
      if (OFS_BITS + NSEL > WIN_BITS) begin : g_bad_fields
         $error("cfgwin_decode: select field does not fit in window");
      end
   endgenerate

endmodule

// File: rtl/cfgwin_lanes.sv
module cfgwin_lanes
   import cfgwin_pkg::*;
#(
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [31:0] din,
   input  acc_size_e   size,
   output logic [31:0] dout
);
   generate
      if (BIG_ENDIAN) begin : g_swap
         always_comb begin
            case (size)
               SZ_BYTE: dout = {24'h0, din[7:0]};
               SZ_HALF: dout = {16'h0, din[7:0], din[15:8]};
               default: dout = {din[7:0], din[15:8], din[23:16], din[31:24]};
            endcase
         end
      end else begin : g_pass
         always_comb begin
            case (size)
               SZ_BYTE: dout = {24'h0, din[7:0]};
               SZ_HALF: dout = {16'h0, din[15:0]};
               default: dout = din;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/cfgwin_header.sv
module cfgwin_header #(
   parameter int          OFS_BITS  = 11,
   parameter logic [15:0] VENDOR    = 16'h1F2E,
   parameter logic [15:0] DEVICE    = 16'h4801,
   parameter logic [7:0]  REVISION  = 8'h00,
   parameter logic [23:0] CLASS     = 24'h06_00_00,
   parameter logic [7:0]  LINE_SIZE = 8'h08,
   parameter logic [7:0]  LAT_TIMER = 8'h10,
   parameter logic [7:0]  CAP_PTR   = 8'h00
) (
   input  logic [OFS_BITS-1:0] ofs,
   output logic [31:0]         raw
);
   logic [31:0] dword;

   always_comb begin
      dword = '0;
      if (ofs[OFS_BITS-1:8] == '0) begin
         case (ofs[7:2])
            6'h00:   dword = {DEVICE, VENDOR};
            6'h02:   dword = {CLASS, REVISION};
            6'h03:   dword = {8'h00, 8'h00, LAT_TIMER, LINE_SIZE};
            6'h0D:   dword = {24'h0, CAP_PTR};
            default: dword = '0;
         endcase
      end
   end

   assign raw = dword >> {ofs[1:0], 3'b000};

   generate
      if (OFS_BITS < 9) begin : g_bad_ofs
         $error("cfgwin_header: offset field too narrow for header");
      end
   endgenerate

endmodule

// File: rtl/cfgwin_bridge.sv
module cfgwin_bridge
   import cfgwin_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h8080_0000,
   parameter int                WIN_BITS   = 22,
   parameter int                OFS_BITS   = 11,
   parameter int                NSEL       = 11,
   parameter int                SELF_IDX   = NSEL,
   parameter bit                BIG_ENDIAN = 1'b1,
   parameter logic [15:0]       VENDOR     = 16'h1F2E,
   parameter logic [15:0]       DEVICE     = 16'h4801,
   localparam int               IDX_W      = $clog2(NSEL + 1),
   localparam int               CFG_AW     = OFS_BITS + IDX_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_valid,
   output logic              cpu_ready,
   input  logic              cpu_write,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [1:0]        cpu_size,
   input  logic [31:0]       cpu_wdata,
   output logic              cpu_rvalid,
   input  logic              cpu_rready,
   output logic [31:0]       cpu_rdata,
   output logic              cfg_valid,
   input  logic              cfg_ready,
   output logic              cfg_write,
   output logic [CFG_AW-1:0] cfg_addr,
   output logic [1:0]        cfg_size,
   output logic [31:0]       cfg_wdata,
   input  logic [31:0]       cfg_rdata,
   input  logic              cfg_nodev
);
   bridge_st_e         state_q;
   logic               dec_hit;
   logic [IDX_W-1:0]   dec_idx;
   logic [OFS_BITS-1:0] dec_ofs;
   acc_size_e          req_size;
   logic               accept;
   logic               to_self;
   logic [31:0]        wr_lanes;
   logic [31:0]        hdr_raw;
   logic [31:0]        hdr_lanes;
   logic [31:0]        rd_lanes;

   logic               cfg_write_q;
   logic [CFG_AW-1:0]  cfg_addr_q;
   acc_size_e          cfg_size_q;
   logic [31:0]        cfg_wdata_q;
   logic [31:0]        rdata_q;

   assign req_size = acc_size_e'(cpu_size);

   cfgwin_decode #(
      .ADDR_W   (ADDR_W),
      .WIN_BASE (WIN_BASE),
      .WIN_BITS (WIN_BITS),
      .OFS_BITS (OFS_BITS),
      .NSEL     (NSEL)
   ) u_decode (
      .addr (cpu_addr),
      .hit  (dec_hit),
      .idx  (dec_idx),
      .ofs  (dec_ofs)
   );

   cfgwin_lanes #(.BIG_ENDIAN(BIG_ENDIAN)) u_wr_lanes (
      .din  (cpu_wdata),
      .size (req_size),
      .dout (wr_lanes)
   );

   cfgwin_header #(
      .OFS_BITS (OFS_BITS),
      .VENDOR   (VENDOR),
      .DEVICE   (DEVICE)
   ) u_header (
      .ofs (dec_ofs),
      .raw (hdr_raw)
   );

   cfgwin_lanes #(.BIG_ENDIAN(BIG_ENDIAN)) u_hdr_lanes (
      .din  (hdr_raw),
      .size (req_size),
      .dout (hdr_lanes)
   );

   cfgwin_lanes #(.BIG_ENDIAN(BIG_ENDIAN)) u_rd_lanes (
      .din  (cfg_rdata),
      .size (cfg_size_q),
      .dout (rd_lanes)
   );

   assign to_self   = (dec_idx == IDX_W'(SELF_IDX));
   assign cpu_ready = (state_q == ST_IDLE) && dec_hit && (req_size != SZ_BAD);
   assign accept    = cpu_valid && cpu_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_IDLE;
         cfg_write_q <= 1'b0;
         cfg_addr_q  <= '0;
         cfg_size_q  <= SZ_BYTE;
         cfg_wdata_q <= '0;
         rdata_q     <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (to_self) begin
                     if (!cpu_write) begin
                        rdata_q <= hdr_lanes;
                        state_q <= ST_RESP;
                     end
                  end else begin
                     cfg_write_q <= cpu_write;
                     cfg_addr_q  <= {dec_idx, dec_ofs};
                     cfg_size_q  <= req_size;
                     cfg_wdata_q <= cpu_write ? wr_lanes : '0;
                     state_q     <= ST_CFG;
                  end
               end
            end
            ST_CFG: begin
               if (cfg_ready) begin
                  if (cfg_write_q) begin
                     state_q <= ST_IDLE;
                  end else begin
                     rdata_q <= cfg_nodev ? size_ones(cfg_size_q) : rd_lanes;
                     state_q <= ST_RESP;
                  end
               end
            end
            ST_RESP: begin
               if (cpu_rready) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cfg_valid  = (state_q == ST_CFG);
   assign cfg_write  = cfg_write_q;
   assign cfg_addr   = cfg_addr_q;
   assign cfg_size   = cfg_size_q;
   assign cfg_wdata  = cfg_wdata_q;
   assign cpu_rvalid = (state_q == ST_RESP);
   assign cpu_rdata  = rdata_q;

   generate
      if (WIN_BITS >= ADDR_W || SELF_IDX > NSEL || WIN_BASE[WIN_BITS-1:0] != '0) begin : g_bad_top
         $error("cfgwin_bridge: window or self index parameters out of range");
      end
   endgenerate

   // R1: only in-window addresses are ever claimed
   a_r1_claim_in_window: assert property (@(posedge clk) disable iff (rst)
      cpu_ready |-> (cpu_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]));

   // R2: the chosen select bit is set in the address
   a_r2_index_bit_set: assert property (@(posedge clk) disable iff (rst)
      (accept && dec_idx < IDX_W'(NSEL)) |-> cpu_addr[OFS_BITS + 32'(dec_idx)]);

   // R4: size code 3 is never claimed
   a_r4_no_bad_size: assert property (@(posedge clk) disable iff (rst)
      cpu_ready |-> (cpu_size != 2'd3));

   // R9: an accepted read keeps the port busy
   a_r9_read_blocks: assert property (@(posedge clk) disable iff (rst)
      (cpu_valid && cpu_ready && !cpu_write) |=> ((cfg_valid || cpu_rvalid) && !cpu_ready));

   // R10: pending configuration request is held
   a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
      (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_addr) && $stable(cfg_wdata)
                                     && $stable(cfg_size) && $stable(cfg_write)));

   // R11: response held until taken
   a_r11_resp_hold: assert property (@(posedge clk) disable iff (rst)
      (cpu_rvalid && !cpu_rready) |=> (cpu_rvalid && $stable(cpu_rdata)));

   // R7: missing device reads as sized all ones
   a_r7_nodev_ones: assert property (@(posedge clk) disable iff (rst)
      (cfg_valid && cfg_ready && !cfg_write && cfg_nodev)
         |=> (cpu_rvalid && cpu_rdata == size_ones(acc_size_e'($past(cfg_size)))));

   // R9: never a configuration request and a response at once
   a_r9_single_phase: assert property (@(posedge clk) disable iff (rst)
      $onehot0({cfg_valid, cpu_rvalid}));

endmodule

// File: tb/cfgwin_bridge_test.sv
module cfgwin_bridge_test;

   localparam logic [31:0] BASE = 32'h8080_0000;
   localparam logic [15:0] VEN  = 16'h1F2E;
   localparam logic [15:0] DEV  = 16'h4801;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cpu_valid = 1'b0;
   logic        cpu_ready;
   logic        cpu_write = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [1:0]  cpu_size = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_rvalid;
   logic        cpu_rready = 1'b0;
   logic [31:0] cpu_rdata;
   logic        cfg_valid;
   logic        cfg_ready = 1'b0;
   logic        cfg_write;
   logic [14:0] cfg_addr;
   logic [1:0]  cfg_size;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata = '0;
   logic        cfg_nodev = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] seed = 32'h1234_5677;

   always #2 clk = ~clk;

   cfgwin_bridge uut (
      .clk(clk), .rst(rst),
      .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
      .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
      .cpu_rvalid(cpu_rvalid), .cpu_rready(cpu_rready), .cpu_rdata(cpu_rdata),
      .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_write(cfg_write),
      .cfg_addr(cfg_addr), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cfg_nodev(cfg_nodev)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] lanes(input logic [31:0] d, input int sz);
      if (sz == 0) return d & 32'hFF;
      if (sz == 1) return ((d & 32'hFF) << 8) | ((d >> 8) & 32'hFF);
      return ((d & 32'hFF) << 24) | (((d >> 8) & 32'hFF) << 16) |
             (((d >> 16) & 32'hFF) << 8) | ((d >> 24) & 32'hFF);
   endfunction

   function automatic logic [31:0] ones(input int sz);
      return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   function automatic logic [31:0] hdr_dw(input int o);
      if (o >= 256) return 32'h0;
      case (o / 4)
         0:  return {DEV, VEN};
         2:  return 32'h0600_0000;
         3:  return 32'h0000_1008;
         13: return 32'h0000_0000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] next_rand();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed ^ (seed >> 13);
   endfunction

   // forwarded transaction to device idx (0..10)
   task automatic fwd(input int idx, input int ofs, input bit wr, input int sz,
                      input logic [31:0] wd, input logic [31:0] rd, input bit nodev,
                      input int dly, input bit noise);
      logic [31:0] a;
      logic [31:0] exp;
      logic [31:0] want_addr;
      a = BASE | (32'd1 << (11 + idx)) | 32'(ofs);
      if (noise && idx < 10) a = a | 32'h0020_0000;
      want_addr = (32'(idx) << 11) | 32'(ofs);
      @(negedge clk);
      cpu_addr = a; cpu_write = wr; cpu_size = 2'(sz); cpu_wdata = wd; cpu_valid = 1'b1;
      #1;
      chk(cpu_ready === 1'b1, "R1", "in-window claim", 32'(cpu_ready), 32'd1);
      @(negedge clk);
      chk(cfg_valid === 1'b1, "R3", "cfg_valid after accept", 32'(cfg_valid), 32'd1);
      chk(32'(cfg_addr) === want_addr, "R2", "cfg_addr index/offset", 32'(cfg_addr), want_addr);
      chk(32'(cfg_size) === 32'(sz) && cfg_write === wr, "R3", "cfg size/write",
          {29'd0, cfg_write, cfg_size}, {29'd0, wr, 2'(sz)});
      if (wr) chk(cfg_wdata === lanes(wd, sz), "R5", "write lanes", cfg_wdata, lanes(wd, sz));
      chk(cpu_ready === 1'b0, "R9", "busy while pending", 32'(cpu_ready), 32'd0);
      for (int k = 0; k < dly; k++) begin
         @(negedge clk);
         chk(cfg_valid === 1'b1 && 32'(cfg_addr) === want_addr, "R10", "request held",
             32'(cfg_addr), want_addr);
         chk(cpu_ready === 1'b0, "R9", "busy while waiting", 32'(cpu_ready), 32'd0);
      end
      cfg_ready = 1'b1; cfg_rdata = rd; cfg_nodev = nodev;
      @(negedge clk);
      cfg_ready = 1'b0; cfg_nodev = 1'b0; cfg_rdata = ~rd;
      chk(cfg_valid === 1'b0, "R9", "request ends at ack", 32'(cfg_valid), 32'd0);
      if (wr) begin
         chk(cpu_rvalid === 1'b0, "R9", "no response for write", 32'(cpu_rvalid), 32'd0);
         chk(cpu_ready === 1'b1, "R9", "free after write ack", 32'(cpu_ready), 32'd1);
         cpu_valid = 1'b0;
      end else begin
         chk(cpu_ready === 1'b0, "R9", "busy until response taken", 32'(cpu_ready), 32'd0);
         cpu_valid = 1'b0;
         exp = nodev ? ones(sz) : lanes(rd, sz);
         chk(cpu_rvalid === 1'b1 && cpu_rdata === exp, nodev ? "R7" : "R6", "read data",
             cpu_rdata, exp);
         @(negedge clk);
         chk(cpu_rvalid === 1'b1 && cpu_rdata === exp, "R11", "response held",
             cpu_rdata, exp);
         cpu_rready = 1'b1;
         @(negedge clk);
         cpu_rready = 1'b0;
         chk(cpu_rvalid === 1'b0, "R11", "response taken", 32'(cpu_rvalid), 32'd0);
      end
   endtask

   task automatic self_read(input int o, input int sz);
      logic [31:0] exp;
      exp = lanes(hdr_dw(o) >> (8 * (o % 4)), sz);
      @(negedge clk);
      cpu_addr = BASE | 32'(o); cpu_write = 1'b0; cpu_size = 2'(sz); cpu_valid = 1'b1;
      #1;
      chk(cpu_ready === 1'b1, "R2", "no select bit claimed", 32'(cpu_ready), 32'd1);
      @(negedge clk);
      cpu_valid = 1'b0;
      chk(cfg_valid === 1'b0, "R8", "header not forwarded", 32'(cfg_valid), 32'd0);
      chk(cpu_rvalid === 1'b1 && cpu_rdata === exp, "R8", "header read", cpu_rdata, exp);
      cpu_rready = 1'b1;
      @(negedge clk);
      cpu_rready = 1'b0;
   endtask

   task automatic self_write(input int o, input int sz, input logic [31:0] d);
      @(negedge clk);
      cpu_addr = BASE | 32'(o); cpu_write = 1'b1; cpu_size = 2'(sz); cpu_wdata = d; cpu_valid = 1'b1;
      @(negedge clk);
      cpu_valid = 1'b0;
      chk(cfg_valid === 1'b0 && cpu_rvalid === 1'b0, "R8", "header write dropped",
          {30'd0, cfg_valid, cpu_rvalid}, 32'd0);
      chk(cpu_ready === 1'b1, "R8", "free next cycle", 32'(cpu_ready), 32'd1);
   endtask

   task automatic outside(input logic [31:0] a, input int sz, input string req);
      @(negedge clk);
      cpu_addr = a; cpu_write = 1'b0; cpu_size = 2'(sz); cpu_valid = 1'b1;
      #1;
      chk(cpu_ready === 1'b0, req, "not claimed", 32'(cpu_ready), 32'd0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(cfg_valid === 1'b0 && cpu_rvalid === 1'b0, req, "nothing issued",
             {30'd0, cfg_valid, cpu_rvalid}, 32'd0);
      end
      cpu_valid = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(cfg_valid === 1'b0 && cpu_rvalid === 1'b0, "R12", "reset state",
          {30'd0, cfg_valid, cpu_rvalid}, 32'd0);
      rst = 1'b0;

      // forwarded sweep over every device index, size and direction
      for (int idx = 0; idx < 11; idx++)
         for (int sz = 0; sz < 3; sz++)
            for (int wr = 0; wr < 2; wr++) begin
               int ofs;
               ofs = ((idx * 37 + sz * 5 + wr * 200) & 32'h7FF) & ~((1 << sz) - 1);
               fwd(idx, ofs, wr[0], sz, next_rand(), next_rand(), 1'b0,
                   (idx + sz + wr) % 3, ((idx + wr) % 2) == 1);
            end

      // missing-device reads
      for (int sz = 0; sz < 3; sz++) fwd(3 + sz, 16 * sz, 1'b0, sz, 0, next_rand(), 1'b1, sz, 1'b1);

      // own header, every aligned offset of the first 64 bytes
      for (int sz = 0; sz < 3; sz++)
         for (int o = 0; o < 64; o += (1 << sz)) self_read(o, sz);
      self_read(32'h100, 2);
      self_read(32'h7FC, 2);

      // header writes are dropped
      self_write(0, 2, 32'hFFFF_FFFF);
      self_write(12, 1, 32'h0000_5A5A);
      self_read(0, 2);
      self_read(12, 2);

      // out-of-window and bad size
      outside(BASE - 32'd4, 2, "R1");
      outside(BASE + 32'h0040_0000, 0, "R1");
      outside(32'h0000_0000, 1, "R1");
      outside(32'hFFFF_FFFC, 2, "R1");
      outside(BASE | 32'h0000_1000, 3, "R4");

      // reset during a pending configuration read
      @(negedge clk);
      cpu_addr = BASE | 32'h0001_0004; cpu_write = 1'b0; cpu_size = 2'd2; cpu_valid = 1'b1;
      @(negedge clk);
      cpu_valid = 1'b0;
      chk(cfg_valid === 1'b1, "R12", "pending before reset", 32'(cfg_valid), 32'd1);
      rst = 1'b1;
      @(negedge clk);
      chk(cfg_valid === 1'b0 && cpu_rvalid === 1'b0, "R12", "reset mid-transaction",
          {30'd0, cfg_valid, cpu_rvalid}, 32'd0);
      rst = 1'b0;
      fwd(9, 8, 1'b0, 2, 0, 32'hA1B2_C3D4, 1'b0, 1, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule